// File: doc/BRIEF.md
# DMA Channel Address Generator

This block keeps the running address for one side of a DMA channel. A controller loads a start address together with an access-size code, a signed per-access step, a circular-window code, an optional signed minor-loop offset and a signed major-loop adjustment. It then pulses step inputs as each access, minor loop and major loop completes. The block answers with the registered current address, the number of byte lanes per access, and two misalignment flags.

One module serves both the read side and the write side of a channel, so a channel uses two instances. Address wrap keeps all address bits above a chosen boundary fixed, which lets a channel cycle through a circular buffer whose size is a power of two. Bus transactions, iteration counting and arbitration are left to the surrounding controller.

Top module: `dma_addr_gen`

## Requirements
- R1: The size code maps 0,1,2,3,4,5 to 1,2,4,8,16,32 bytes, and `lane_bytes` shows that count for the size code captured at the last load. Codes 6 and 7 give `lane_bytes` = 0 and raise `err_addr`.
- R2: While `load` is high, the next cycle shows `addr` = `cfg_start_addr`, and all configuration inputs are captured. `load` takes precedence over any step pulse in the same cycle.
- R3: An `step_acc` pulse adds the sign-extended 16-bit `cfg_acc_off` to the address.
- R4: A window code of 0 disables wrap. A code n from 1 to 31 lets an addition change only address bits [n-1:0], with the sum taken modulo 2^n. All higher bits keep their value.
- R5: When `cfg_minor_en` was 1 at load, a `step_minor` pulse adds the sign-extended `cfg_minor_off`. When it was 0, `step_minor` leaves the address unchanged.
- R6: A `step_major` pulse adds the signed 32-bit `cfg_major_adj` to the address.
- R7: At load, `err_addr` is set when the start address is not a multiple of the access size, and cleared otherwise.
- R8: At load, `err_off` is set when `cfg_acc_off` is not a multiple of the access size, and cleared otherwise. It is 0 for size codes 6 and 7.
- R9: While either error flag is set, step pulses leave the address unchanged. A later load with a clean configuration clears the flags and allows updates again.
- R10: When pulses coincide, they apply in a fixed order: the access step first, then the minor offset, then the major adjustment. The wrap applies after each addition.
- R11: The address changes exactly one cycle after the cycle that holds a load or step pulse. With no pulse it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Capture configuration and start address |
| cfg_start_addr | input | AW | Start address |
| cfg_size | input | 3 | Access-size code |
| cfg_acc_off | input | OW | Signed per-access step |
| cfg_mod | input | 5 | Circular-window code |
| cfg_minor_en | input | 1 | Enable for the minor-loop offset |
| cfg_minor_off | input | MW | Signed minor-loop offset |
| cfg_major_adj | input | JW | Signed major-loop adjustment |
| step_acc | input | 1 | An access has completed |
| step_minor | input | 1 | A minor loop has completed |
| step_major | input | 1 | The major count is exhausted |
| addr | output | AW | Current address |
| lane_bytes | output | 6 | Bytes per access |
| err_addr | output | 1 | Start address misaligned or size code invalid |
| err_off | output | 1 | Per-access step misaligned |

## Verification
A wrong adder input, a wrong stage order or a wrong window mask shows on `addr` in the cycle after the first pulse that uses it, and it stays there for every later step. For this reason the bench compares against an arithmetic modulo model after every cycle. A flag latched wrongly at load shows at once on `err_addr` or `err_off`. A missing update block shows as address movement on the first step after a bad load. A frozen high bit that gets corrupted under wrap never heals, so every later address differs from the model.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;

  // bits a window code leaves free to change (all for code 0)
  function automatic logic [63:0] win_mask(input logic [4:0] code);
    if (code == 5'd0) return '1;
    return (64'd1 << code) - 64'd1;
  endfunction

  // add and keep bits above the window fixed
  function automatic logic [63:0] wrap_add(input logic [63:0] base,
                                           input logic [63:0] addend,
                                           input logic [4:0]  code);
    logic [63:0] sum;
    logic [63:0] mk;
    sum = base + addend;
    mk  = win_mask(code);
    return (base & ~mk) | (sum & mk);
  endfunction

  // bytes per access, zero for unsupported codes
  function automatic logic [5:0] lane_of(input logic [2:0] code);
    if (code > 3'd5) return 6'd0;
    return 6'd1 << code;
  endfunction

endpackage

// File: rtl/dma_ag_align_chk.sv
module dma_ag_align_chk #(
  parameter int AW = 32,
  parameter int OW = 16
) (
  input  logic [AW-1:0] start_addr,
  input  logic [2:0]    size_code,
  input  logic [OW-1:0] acc_off,
  output logic          bad_addr,
  output logic          bad_off
);
  import dma_ag_pkg::*;

  logic [5:0] lanes;
  logic [5:0] low_mask;
  logic       size_bad;

  assign lanes    = lane_of(size_code);
  assign size_bad = (lanes == 6'd0);
  assign low_mask = lanes - 6'd1;

  always_comb begin
    bad_addr = size_bad;
    bad_off  = 1'b0;
    if (!size_bad) begin
      bad_addr = |(6'(start_addr) & low_mask);
      bad_off  = |(6'(acc_off) & low_mask);
    end
  end

endmodule

// File: rtl/dma_ag_step_chain.sv
module dma_ag_step_chain #(
  parameter int AW = 32,
  parameter int NS = 3
) (
  input  logic [AW-1:0]         addr_in,
  input  logic [NS-1:0]         stage_en,
  input  logic [NS-1:0][AW-1:0] stage_add,
  input  logic [4:0]            win_code,
  output logic [AW-1:0]         addr_out
);
  import dma_ag_pkg::*;

  logic [NS:0][AW-1:0] chain;

  assign chain[0] = addr_in;

  for (genvar s = 0; s < NS; s++) begin : g_stage
    logic [AW-1:0] stage_sum;
    assign stage_sum  = AW'(wrap_add(64'(chain[s]), 64'(stage_add[s]), win_code));
    assign chain[s+1] = stage_en[s] ? stage_sum : chain[s];
  end

  assign addr_out = chain[NS];

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int AW = 32,
  parameter int OW = 16,
  parameter int MW = 32,
  parameter int JW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] cfg_start_addr,
  input  logic [2:0]    cfg_size,
  input  logic [OW-1:0] cfg_acc_off,
  input  logic [4:0]    cfg_mod,
  input  logic          cfg_minor_en,
  input  logic [MW-1:0] cfg_minor_off,
  input  logic [JW-1:0] cfg_major_adj,
  input  logic          step_acc,
  input  logic          step_minor,
  input  logic          step_major,
  output logic [AW-1:0] addr,
  output logic [5:0]    lane_bytes,
  output logic          err_addr,
  output logic          err_off
);
  import dma_ag_pkg::*;

  localparam int NSTAGE = 3;

  logic [AW-1:0] addr_q;
  logic [4:0]    mod_q;
  logic [2:0]    size_q;
  logic [OW-1:0] aoff_q;
  logic          men_q;
  logic [MW-1:0] moff_q;
  logic [JW-1:0] madj_q;
  logic          ea_q, eo_q;

  logic          ea_d, eo_d;
  logic          blocked;
  logic          any_step;
  logic          upd_en;
  logic [NSTAGE-1:0]         st_en;
  logic [NSTAGE-1:0][AW-1:0] st_add;
  logic [AW-1:0] addr_next;
  logic [AW-1:0] frozen_mask;

  dma_ag_align_chk #(.AW(AW), .OW(OW)) u_align (
    .start_addr (cfg_start_addr),
    .size_code  (cfg_size),
    .acc_off    (cfg_acc_off),
    .bad_addr   (ea_d),
    .bad_off    (eo_d)
  );

  // stage order: access step, minor offset, major adjustment
  assign st_en[0]  = step_acc;
  assign st_en[1]  = step_minor & men_q;
  assign st_en[2]  = step_major;
  assign st_add[0] = AW'($signed(aoff_q));
  assign st_add[1] = AW'($signed(moff_q));
  assign st_add[2] = AW'($signed(madj_q));

  dma_ag_step_chain #(.AW(AW), .NS(NSTAGE)) u_chain (
    .addr_in  (addr_q),
    .stage_en (st_en),
    .stage_add(st_add),
    .win_code (mod_q),
    .addr_out (addr_next)
  );

  assign blocked     = ea_q | eo_q;
  assign any_step    = step_acc | step_minor | step_major;
  assign upd_en      = any_step & ~blocked & ~load;
  assign frozen_mask = ~AW'(win_mask(mod_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mod_q  <= '0;
      size_q <= '0;
      aoff_q <= '0;
      men_q  <= 1'b0;
      moff_q <= '0;
      madj_q <= '0;
      ea_q   <= 1'b0;
      eo_q   <= 1'b0;
    end else if (load) begin
      addr_q <= cfg_start_addr;
      mod_q  <= cfg_mod;
      size_q <= cfg_size;
      aoff_q <= cfg_acc_off;
      men_q  <= cfg_minor_en;
      moff_q <= cfg_minor_off;
      madj_q <= cfg_major_adj;
      ea_q   <= ea_d;
      eo_q   <= eo_d;
    end else if (upd_en) begin
      addr_q <= addr_next;
    end
  end

  assign addr       = addr_q;
  assign lane_bytes = lane_of(size_q);
  assign err_addr   = ea_q;
  assign err_off    = eo_q;

  // R2
  load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (addr == $past(cfg_start_addr)));

  // R7
  err_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ((err_addr == $past(ea_d)) && (err_off == $past(eo_d))));

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && !load) |=> $stable(addr));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !any_step) |=> $stable(addr));

  // R4
  win_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && mod_q != 5'd0) |=> ((addr & $past(frozen_mask)) == ($past(addr) & $past(frozen_mask))));

  // R1
  lane_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_bytes));

endmodule

// File: tb/tb_dma_addr_gen.sv
module tb_dma_addr_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [31:0] cfg_start_addr = '0;
  logic [2:0]  cfg_size = '0;
  logic [15:0] cfg_acc_off = '0;
  logic [4:0]  cfg_mod = '0;
  logic        cfg_minor_en = 1'b0;
  logic [31:0] cfg_minor_off = '0;
  logic [31:0] cfg_major_adj = '0;
  logic        step_acc = 1'b0, step_minor = 1'b0, step_major = 1'b0;
  logic [31:0] addr;
  logic [5:0]  lane_bytes;
  logic        err_addr, err_off;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dma_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .load(load),
    .cfg_start_addr(cfg_start_addr), .cfg_size(cfg_size),
    .cfg_acc_off(cfg_acc_off), .cfg_mod(cfg_mod),
    .cfg_minor_en(cfg_minor_en), .cfg_minor_off(cfg_minor_off),
    .cfg_major_adj(cfg_major_adj),
    .step_acc(step_acc), .step_minor(step_minor), .step_major(step_major),
    .addr(addr), .lane_bytes(lane_bytes), .err_addr(err_addr), .err_off(err_off)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // modulo-arithmetic reference: window base plus wrapped low part
  function automatic longint model(input longint a, input longint off, input int m);
    longint w, base, x;
    if (m == 0) return (a + off) & 64'hFFFF_FFFF;
    w    = longint'(1) << m;
    base = a - (a % w);
    x    = (a % w) + off;
    x    = ((x % w) + w) % w;
    return base + x;
  endfunction

  task automatic do_load(input logic [31:0] sa, input logic [2:0] sz, input logic [15:0] ao,
                         input logic [4:0] md, input logic men, input logic [31:0] mo,
                         input logic [31:0] mj);
    cfg_start_addr = sa; cfg_size = sz; cfg_acc_off = ao; cfg_mod = md;
    cfg_minor_en = men; cfg_minor_off = mo; cfg_major_adj = mj;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    longint exp;
    logic [31:0] sa;
    logic [2:0]  sz;
    logic [15:0] ao;
    logic [4:0]  md;
    logic        men;
    logic [31:0] mo, mj;

    repeat (3) @(negedge clk);
    chk(addr == 0 && !err_addr && !err_off && lane_bytes == 6'd1, "reset R11", addr, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R7: size and start-address alignment sweep
    for (int s = 0; s < 8; s++) begin
      for (int k = 0; k < 32; k++) begin
        do_load(32'h1000_0000 + k, 3'(s), 16'd0, 5'd0, 1'b0, 0, 0);
        chk(addr == 32'h1000_0000 + k, "R2 load", addr, 32'h1000_0000 + k);
        chk(err_addr == ((s > 5) || (k % (1 << s)) != 0), "R7 err_addr", err_addr,
            (s > 5) || (k % (1 << s)) != 0);
        chk(lane_bytes == ((s > 5) ? 6'd0 : 6'(1 << s)), "R1 lane_bytes", lane_bytes,
            (s > 5) ? 0 : (1 << s));
        if (s > 5) chk(err_off == 1'b0, "R8 err_off invalid size", err_off, 0);
      end
    end

    // R8: offset alignment sweep
    for (int s = 0; s < 6; s++) begin
      for (int o = -33; o <= 33; o++) begin
        do_load(32'h0, 3'(s), 16'(o), 5'd0, 1'b0, 0, 0);
        chk(err_off == ((o % (1 << s)) != 0), "R8 err_off", err_off, (o % (1 << s)) != 0);
        chk(err_addr == 1'b0, "R7 err_addr aligned", err_addr, 0);
      end
    end

    // R3 R4 R5 R6 R10 R11: step sequences over several configurations
    for (int c = 0; c < 6; c++) begin
      case (c)
        0: begin sa = 32'h2000_0000; sz = 3'd2; ao = 16'd4;     md = 5'd0;  men = 1; mo = -32'sd12;   mj = 32'h100; end
        1: begin sa = 32'h3000_00F0; sz = 3'd2; ao = 16'd8;     md = 5'd4;  men = 1; mo = 32'd20;     mj = -32'sd64; end
        2: begin sa = 32'h0000_0055; sz = 3'd0; ao = 16'hFFFF;  md = 5'd1;  men = 1; mo = 32'd3;      mj = 32'd5; end
        3: begin sa = 32'h8000_0010; sz = 3'd3; ao = 16'hFFF8;  md = 5'd31; men = 0; mo = 32'h40;     mj = 32'h8000_0000; end
        4: begin sa = 32'h0ABC_DE00; sz = 3'd5; ao = 16'd32;    md = 5'd8;  men = 1; mo = -32'sd96;   mj = 32'h1000; end
        default: begin sa = 32'h0000_0012; sz = 3'd1; ao = 16'd6; md = 5'd3; men = 1; mo = 32'd2;    mj = -32'sd2; end
      endcase
      do_load(sa, sz, ao, md, men, mo, mj);
      chk(!err_addr && !err_off, "R7 R8 clean config", {err_addr, err_off}, 0);
      exp = sa;
      for (int i = 0; i < 40; i++) begin
        int p;
        p = (i * 5 + c) % 8;
        step_acc = p[0]; step_minor = p[1]; step_major = p[2];
        if (p[0]) exp = model(exp, longint'($signed(ao)), md);
        if (p[1] && men) exp = model(exp, longint'($signed(mo)), md);
        if (p[2]) exp = model(exp, longint'($signed(mj)), md);
        @(negedge clk);
        step_acc = 0; step_minor = 0; step_major = 0;
        chk(addr == 32'(exp), $sformatf("R10 R3 R4 R5 R6 cfg%0d step%0d", c, i), addr, exp);
      end
      @(negedge clk);
      chk(addr == 32'(exp), "R11 idle hold", addr, exp);
    end

    // R5: minor step ignored when disabled
    do_load(32'h4000, 3'd2, 16'd4, 5'd0, 1'b0, 32'h100, 0);
    step_minor = 1; @(negedge clk); step_minor = 0;
    chk(addr == 32'h4000, "R5 minor disabled", addr, 32'h4000);

    // R9: errors block updates until a clean reload
    do_load(32'h1001, 3'd2, 16'd4, 5'd0, 1'b1, 32'd8, 32'd16);
    chk(err_addr == 1'b1, "R9 err set", err_addr, 1);
    for (int i = 0; i < 4; i++) begin
      step_acc = 1; step_minor = 1; step_major = 1;
      @(negedge clk);
      chk(addr == 32'h1001, "R9 blocked", addr, 32'h1001);
    end
    step_acc = 0; step_minor = 0; step_major = 0;
    do_load(32'h1000, 3'd2, 16'd6, 5'd0, 1'b0, 0, 0);
    chk(err_off == 1'b1 && err_addr == 1'b0, "R9 R8 off error", {err_addr, err_off}, 1);
    step_acc = 1; @(negedge clk); step_acc = 0;
    chk(addr == 32'h1000, "R9 blocked by offset", addr, 32'h1000);
    do_load(32'h1000, 3'd2, 16'd4, 5'd0, 1'b0, 0, 0);
    step_acc = 1; @(negedge clk); step_acc = 0;
    chk(addr == 32'h1004, "R9 released", addr, 32'h1004);

    // R2: load wins over coincident steps
    cfg_start_addr = 32'h7700; cfg_size = 3'd0; cfg_acc_off = 16'd1; cfg_mod = 5'd0;
    cfg_minor_en = 1; cfg_minor_off = 32'd1; cfg_major_adj = 32'd1;
    load = 1; step_acc = 1; step_minor = 1; step_major = 1;
    @(negedge clk);
    load = 0; step_acc = 0; step_minor = 0; step_major = 0;
    chk(addr == 32'h7700, "R2 load precedence", addr, 32'h7700);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule